// File: doc/BRIEF.md
# Grouped-Priority Exception Arbiter

This block decides which pending exception or interrupt a processor core should service next, and whether that request is urgent enough to interrupt the handler that is already running. There are sixteen system exception slots, numbered 0 to 15. The periodic tick exception is number 15. External interrupt line n is exception number 16+n. Every source has an 8-bit priority byte. Only its upper four bits are implemented, and a smaller value means a more urgent request.

A run-time grouping setting divides the four implemented bits into two parts. The upper part is the preemption field and the rest is the sub-priority. The arbiter always chooses the single most urgent pending request. It raises a preemption request only when that winner's preemption field is strictly smaller than the field of the active exception. All inputs are captured in registers on the clock edge. The outputs are computed from those registers without further registering.

Top module: `prio_arbiter`

## Requirements
- R1: Among the candidate sources, the winner is the one with the smallest implemented priority value, taken from bits [7:4] of its priority byte.
- R2: When candidates share the same implemented priority value, the lowest exception number wins. A system exception therefore beats an external interrupt of equal priority.
- R3: Rules for candidates and the idle output:
  - System exception i is a candidate when sys_pend[i] is high.
  - External interrupt n is reported as number 16+n, and it is a candidate only when both irq_pend[n] and irq_en[n] are high.
  - With no candidate, win_valid, win_num and preempt_req are all 0.
- R4: Bits [3:0] of every priority byte, including act_prio, have no effect on the outputs.
- R5: Preemption against an active exception:
  - The setting grp = g gives the top min(g,4) implemented bits to the preemption field. Values of 5 to 7 act as 4, and 0 leaves the field empty.
  - With act_valid high, preempt_req is 1 only if the winner's preemption field is numerically below that of act_prio.
- R6: A winner whose preemption field equals the active one never raises preempt_req, even when its sub-priority is lower.
- R7: When act_valid is low, any winner raises preempt_req.
- R8: Outputs reflect the inputs sampled at the most recent rising clock edge. They do not change between edges.
- R9: An active-low asynchronous reset clears all captured state, so that all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sys_pend | input | 16 | Pending flags of system exceptions 0..15 |
| sys_prio | input | 128 | Priority bytes of system exceptions; byte i is bits [8i+7:8i] |
| irq_pend | input | NIRQ | Pending flags of external interrupts |
| irq_en | input | NIRQ | Enable flags of external interrupts |
| irq_prio | input | 8*NIRQ | Priority bytes of external interrupts; byte n is bits [8n+7:8n] |
| grp | input | 3 | Number of implemented bits used as preemption field |
| act_valid | input | 1 | An exception handler is active |
| act_prio | input | 8 | Priority byte of the active exception |
| win_valid | output | 1 | A candidate exists |
| win_num | output | $clog2(16+NIRQ) | Exception number of the winner |
| preempt_req | output | 1 | Winner may preempt the active exception |

## Verification
The bench targets ties of equal priority, both between the tick exception and an external line and between two external lines. A design that scanned in the wrong direction or used a non-strict comparison would report the higher exception number. It also tests a winner whose sub-priority is better than the active exception's while its preemption field is equal. It sweeps grouping values 0, 1, 2, 4 and 7 across that boundary. A design that compared full values, or that did not clamp oversized grouping values, would raise preemption when it should not, or stay silent when it should raise it. Further checks cover junk in the unimplemented low bits, disabled lines that are pending, the one-cycle capture latency, and reprogramming a priority at run time.

// File: rtl/prio_arbiter.sv
module prio_arbiter #(
  parameter int NIRQ  = 8,
  parameter int PBITS = 4,
  localparam int NSRC = 16 + NIRQ,
  localparam int NUMW = $clog2(NSRC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       sys_pend,
  input  logic [16*8-1:0]   sys_prio,
  input  logic [NIRQ-1:0]   irq_pend,
  input  logic [NIRQ-1:0]   irq_en,
  input  logic [NIRQ*8-1:0] irq_prio,
  input  logic [2:0]        grp,
  input  logic              act_valid,
  input  logic [7:0]        act_prio,
  output logic              win_valid,
  output logic [NUMW-1:0]   win_num,
  output logic              preempt_req
);

  logic [NSRC-1:0]            cand_q;
  logic [NSRC-1:0][PBITS-1:0] lvl_d, lvl_q;
  logic [2:0]                 grp_q;
  logic                       actv_q;
  logic [PBITS-1:0]           actl_q;

  for (genvar i = 0; i < NSRC; i++) begin : g_lvl
    if (i < 16) begin : g_sys
      assign lvl_d[i] = sys_prio[i*8+7 -: PBITS];
    end else begin : g_irq
      assign lvl_d[i] = irq_prio[(i-16)*8+7 -: PBITS];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cand_q <= '0;
      lvl_q  <= '0;
      grp_q  <= '0;
      actv_q <= 1'b0;
      actl_q <= '0;
    end else begin
      cand_q <= {irq_pend & irq_en, sys_pend};
      lvl_q  <= lvl_d;
      grp_q  <= grp;
      actv_q <= act_valid;
      actl_q <= act_prio[7 -: PBITS];
    end
  end

  logic             found;
  logic [PBITS-1:0] best_lvl;
  logic [NUMW-1:0]  best_idx;

  always_comb begin
    found    = 1'b0;
    best_lvl = '0;
    best_idx = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (cand_q[i] && (!found || lvl_q[i] < best_lvl)) begin
        found    = 1'b1;
        best_lvl = lvl_q[i];
        best_idx = NUMW'(i);
      end
    end
  end

  logic [2:0]       pre_bits;
  logic [PBITS-1:0] pmask;

  assign pre_bits    = (32'(grp_q) > PBITS) ? 3'(PBITS) : grp_q;
  assign pmask       = ~({PBITS{1'b1}} >> pre_bits);
  assign win_valid   = found;
  assign win_num     = found ? best_idx : '0;
  assign preempt_req = found & (~actv_q | ((best_lvl & pmask) < (actl_q & pmask)));

endmodule

// File: rtl/prio_arbiter_chk.sv
module prio_arbiter_chk #(
  parameter int NSRC = 24,
  parameter int NUMW = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] cand_q,
  input logic [2:0]      grp_q,
  input logic            actv_q,
  input logic            win_valid,
  input logic [NUMW-1:0] win_num,
  input logic            preempt_req
);

  a_r3_preempt_needs_winner: assert property (@(posedge clk) disable iff (!rst_n)
    preempt_req |-> win_valid);

  a_r3_winner_is_candidate: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> (32'(win_num) < NSRC && cand_q[win_num]));

  a_r3_idle_means_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cand_q == '0) |-> (!win_valid && win_num == '0 && !preempt_req));

  a_r7_idle_core_takes_any: assert property (@(posedge clk) disable iff (!rst_n)
    (win_valid && !actv_q) |-> preempt_req);

  a_r5_no_field_no_preempt: assert property (@(posedge clk) disable iff (!rst_n)
    (actv_q && grp_q == 3'd0) |-> !preempt_req);

endmodule

bind prio_arbiter prio_arbiter_chk #(.NSRC(NSRC), .NUMW(NUMW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cand_q(cand_q), .grp_q(grp_q), .actv_q(actv_q),
  .win_valid(win_valid), .win_num(win_num), .preempt_req(preempt_req)
);

// File: tb/tb_prio_arbiter.sv
module tb_prio_arbiter;
  localparam int PERIOD = 10;
  localparam int NVEC   = 17;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [15:0]  sys_pend = '0;
  logic [127:0] sys_prio = '0;
  logic [7:0]   irq_pend = '0, irq_en = '0;
  logic [63:0]  irq_prio = '0;
  logic [2:0]   grp = '0;
  logic         act_valid = 1'b0;
  logic [7:0]   act_prio = '0;
  logic         win_valid, preempt_req;
  logic [4:0]   win_num;

  int checks = 0, fails = 0;

  always #(PERIOD/2) clk = ~clk;

  prio_arbiter dut (
    .clk(clk), .rst_n(rst_n), .sys_pend(sys_pend), .sys_prio(sys_prio),
    .irq_pend(irq_pend), .irq_en(irq_en), .irq_prio(irq_prio), .grp(grp),
    .act_valid(act_valid), .act_prio(act_prio), .win_valid(win_valid),
    .win_num(win_num), .preempt_req(preempt_req)
  );

  // Vector fields: req, sys_pend, irq_pend, irq_en, grp, act_valid, act_prio, exp_valid, exp_num, exp_pre
  // Levels: sys11=4 sys14=C sys15=F, irq0..7 = 5 F 1 4(0x4F) 6 7 2 F
  localparam logic [54:0] VECS [NVEC] = '{
    {4'd3, 16'h0000, 8'h00, 8'hFF, 3'd2, 1'b0, 8'h00, 1'b0, 5'd0,  1'b0}, // R3 nothing pending
    {4'd7, 16'h8000, 8'h00, 8'hFF, 3'd2, 1'b0, 8'h00, 1'b1, 5'd15, 1'b1}, // R7 tick alone, idle core
    {4'd2, 16'h8000, 8'h02, 8'hFF, 3'd2, 1'b0, 8'h00, 1'b1, 5'd15, 1'b1}, // R2 tick vs irq1 equal
    {4'd5, 16'h0000, 8'h02, 8'hFF, 3'd2, 1'b1, 8'hF0, 1'b1, 5'd17, 1'b0}, // R5 equal to active tick
    {4'd5, 16'h0000, 8'h04, 8'hFF, 3'd2, 1'b1, 8'hF0, 1'b1, 5'd18, 1'b1}, // R5 higher preempts
    {4'd3, 16'h0000, 8'h04, 8'hFB, 3'd2, 1'b0, 8'h00, 1'b0, 5'd0,  1'b0}, // R3 disabled line
    {4'd4, 16'h0800, 8'h08, 8'hFF, 3'd2, 1'b0, 8'h00, 1'b1, 5'd11, 1'b1}, // R4 0x4F ties 0x40
    {4'd6, 16'h0000, 8'h08, 8'hFF, 3'd2, 1'b1, 8'h50, 1'b1, 5'd19, 1'b0}, // R6 sub-priority only
    {4'd5, 16'h0000, 8'h08, 8'hFF, 3'd4, 1'b1, 8'h50, 1'b1, 5'd19, 1'b1}, // R5 grp 4
    {4'd5, 16'h0000, 8'h04, 8'hFF, 3'd0, 1'b1, 8'hF0, 1'b1, 5'd18, 1'b0}, // R5 grp 0
    {4'd5, 16'h0000, 8'h10, 8'hFF, 3'd1, 1'b1, 8'hC0, 1'b1, 5'd20, 1'b1}, // R5 grp 1
    {4'd1, 16'h0000, 8'h71, 8'hFF, 3'd2, 1'b1, 8'h20, 1'b1, 5'd22, 1'b0}, // R1 several lines
    {4'd1, 16'h4000, 8'hFF, 8'hFF, 3'd2, 1'b1, 8'h00, 1'b1, 5'd18, 1'b0}, // R1 all pending
    {4'd3, 16'h0000, 8'h00, 8'hFF, 3'd2, 1'b1, 8'hF0, 1'b0, 5'd0,  1'b0}, // R3 active, none pending
    {4'd2, 16'h0000, 8'h82, 8'hFF, 3'd2, 1'b0, 8'h00, 1'b1, 5'd17, 1'b1}, // R2 irq1 vs irq7
    {4'd5, 16'h0000, 8'h08, 8'hFF, 3'd7, 1'b1, 8'h50, 1'b1, 5'd19, 1'b1}, // R5 grp 7 clamps to 4
    {4'd4, 16'h0000, 8'h08, 8'hFF, 3'd4, 1'b1, 8'h4F, 1'b1, 5'd19, 1'b0}  // R4 active low bits
  };

  task automatic check(input int req, input logic ev, input logic [4:0] en, input logic ep);
    checks++;
    if (win_valid !== ev || win_num !== en || preempt_req !== ep) begin
      fails++;
      $display("FAIL R%0d: got valid=%b num=%0d pre=%b, expected valid=%b num=%0d pre=%b",
               req, win_valid, win_num, preempt_req, ev, en, ep);
    end
  endtask

  initial begin
    sys_prio[11*8 +: 8] = 8'h40;
    sys_prio[14*8 +: 8] = 8'hC0;
    sys_prio[15*8 +: 8] = 8'hF0;
    irq_prio = {8'hF0, 8'h20, 8'h70, 8'h60, 8'h4F, 8'h10, 8'hF0, 8'h50};
    irq_en   = 8'hFF;
    sys_pend = 16'h8000;
    irq_pend = 8'h04;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(9, 1'b0, 5'd0, 1'b0); // R9 reset holds outputs at zero
    rst_n = 1'b1;
    @(negedge clk);

    for (int k = 0; k < NVEC; k++) begin
      sys_pend  = VECS[k][50:35];
      irq_pend  = VECS[k][34:27];
      irq_en    = VECS[k][26:19];
      grp       = VECS[k][18:16];
      act_valid = VECS[k][15];
      act_prio  = VECS[k][14:7];
      @(posedge clk);
      @(negedge clk);
      check(int'(VECS[k][54:51]), VECS[k][6], VECS[k][5:1], VECS[k][0]);
    end

    // R8: change is not visible before the next edge
    sys_pend = 16'h8000; irq_pend = 8'h00; act_valid = 1'b0;
    @(posedge clk); @(negedge clk);
    irq_pend = 8'h04;
    #1 check(8, 1'b1, 5'd15, 1'b1);
    @(posedge clk); @(negedge clk);
    check(8, 1'b1, 5'd18, 1'b1);

    // R1: run-time reprogramming of irq1 to the top level
    sys_pend = 16'h0800; irq_pend = 8'h02;
    irq_prio[15:8] = 8'h00;
    @(posedge clk); @(negedge clk);
    check(1, 1'b1, 5'd17, 1'b1);

    // R9: asynchronous reset clears state mid-run
    rst_n = 1'b0;
    #1 check(9, 1'b0, 5'd0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(PERIOD*100000);
    checks++;
    fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule